// File: doc/BRIEF.md
# Four-channel timer output controller

This block generates the output levels of a four-channel timer unit from the counters' per-channel interrupt pulses. Software programs two registers over a 16-bit register bus: an enable register, which allows or freezes each channel's output, and a mode register, which picks how each output is generated. A channel in toggle mode inverts its output on every one of its own interrupt pulses. A channel in follower mode produces a PWM-style waveform: the interrupt of its leader channel drives the output high, and its own interrupt drives it low.

Only channels 0 and 2 can lead. Channels 1 and 2 always follow channel 0. Channel 3 follows channel 0 or channel 2, as chosen by a configuration input. A change written to the mode register is not applied at once. Each channel holds an active mode, and the new setting is copied into it only when that channel's output is next set, reset or toggled while the channel is enabled. Every output is registered.

Top module: `tout_ctrl`

## Requirements
- R1: After reset, tout_o is 0000 and both registers read 0x0000, so every channel starts in toggle mode.
- R2: A word write (we_i=1, byte_i=0) with addr_i=0 loads the enable register, and with addr_i=1 loads the mode register. Bit n of each register belongs to channel n. Reads return the register selected by addr_i on rdata_o in the same cycle. Bits 15:4 of both registers always read 0. Mode bit 0 always reads 0, because channel 0 can only run in toggle mode.
- R3: A byte write (we_i=1, byte_i=1) changes only bits 7:0 of the addressed register, and bits 15:8 keep reading 0.
- R4: An enabled channel whose active mode is toggle (0) inverts its output one clock after each of its own interrupt pulses, and it ignores its leader's pulses.
- R5: An enabled channel whose active mode is follower (1) goes high one clock after a pulse from its leader, and goes low one clock after a pulse of its own.
- R6: When a follower's own pulse and its leader's pulse arrive in the same cycle, the output goes low.
- R7: Channels 1 and 2 are led by channel 0. Channel 3 is led by channel 0 when msel3_i=0 and by channel 2 when msel3_i=1.
- R8: While a channel's enable bit is 0, its output keeps its value and interrupt pulses have no effect on it.
- R9: A channel's active mode takes the written mode bit only at an output event while enabled. An output event is the channel's own pulse, or a leader pulse while the channel is in follower mode. That event is still handled under the previous active mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| byte_i | input | 1 | 1: write only the low byte lane |
| addr_i | input | 1 | 0: enable register, 1: mode register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register |
| irq_i | input | 4 | Per-channel timer interrupt pulses |
| msel3_i | input | 1 | Leader select for channel 3 (0: channel 0, 1: channel 2) |
| tout_o | output | 4 | Timer outputs |

## Verification
A follower's set event (its leader's pulse) and its reset event (its own pulse) can land in the same cycle. The bench provokes this by pulsing channels 0 and 1 together, channels 0 and 2 together, and channels 2 and 3 together with channel 3 led by channel 2. In each of these cycles the affected follower must be low one clock later. The bench also pulses a follower's own interrupt alone, and its leader's alone, so that the set and reset paths can each be told apart from the collision case.

// File: rtl/tout_pkg.sv
package tout_pkg;
  localparam int unsigned NCH    = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 1;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 1'b0,
    REG_MODE   = 1'b1
  } reg_sel_e;

  // channel 0 cannot follow, so its mode bit is fixed at 0
  localparam logic [NCH-1:0] MODE_WMASK = {{(NCH-1){1'b1}}, 1'b0};
endpackage

// File: rtl/tout_regs.sv
module tout_regs
  import tout_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NCH-1:0]    wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    en_o,
  output logic [NCH-1:0]    mode_o
);
  localparam logic [DATA_W-1:0] LOW_LANE = DATA_W'((1 << LANE_W) - 1);

  logic [NCH-1:0] lane;
  logic [NCH-1:0] en_q, mode_q;
  logic [NCH-1:0] en_nx, mode_nx;

  assign lane    = byte_i ? LOW_LANE[NCH-1:0] : '1;
  assign en_nx   = (en_q & ~lane) | (wdata_i & lane);
  assign mode_nx = ((mode_q & ~lane) | (wdata_i & lane)) & MODE_WMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= '0;
    end else if (we_i) begin
      if (addr_i == REG_ENABLE) en_q   <= en_nx;
      if (addr_i == REG_MODE)   mode_q <= mode_nx;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == REG_ENABLE) rdata_o[NCH-1:0] = en_q;
    else                      rdata_o[NCH-1:0] = mode_q;
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/tout_route.sv
module tout_route
  import tout_pkg::*;
(
  input  logic [NCH-1:0] irq_i,
  input  logic           msel3_i,
  output logic [NCH-1:0] lead_o
);
  always_comb begin
    lead_o    = '0;
    lead_o[1] = irq_i[0];
    lead_o[2] = irq_i[0];
    lead_o[3] = msel3_i ? irq_i[2] : irq_i[0];
  end
endmodule

// File: rtl/tout_chan.sv
module tout_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic own_i,
  input  logic lead_i,
  output logic out_o,
  output logic act_o
);
  logic out_q, act_q, evt;

  assign evt = en_i & (own_i | (act_q & lead_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      act_q <= 1'b0;
    end else if (evt) begin
      act_q <= mode_i;
      if (act_q) out_q <= ~own_i;  // reset beats set
      else       out_q <= ~out_q;
    end
  end

  assign out_o = out_q;
  assign act_o = act_q;
endmodule

// File: rtl/tout_ctrl.sv
module tout_ctrl
  import tout_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NCH-1:0]    irq_i,
  input  logic              msel3_i,
  output logic [NCH-1:0]    tout_o
);
  logic [NCH-1:0] en_w, mode_w, lead_w, act_w;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NCH];

  tout_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .byte_i(byte_i),
    .addr_i(addr_i), .wdata_i(wdata_i[NCH-1:0]), .rdata_o(rdata_o),
    .en_o(en_w), .mode_o(mode_w)
  );

  tout_route u_route (.irq_i(irq_i), .msel3_i(msel3_i), .lead_o(lead_w));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    tout_chan u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_w[k]), .mode_i(mode_w[k]),
      .own_i(irq_i[k]), .lead_i(lead_w[k]), .out_o(tout_o[k]), .act_o(act_w[k])
    );
  end
endmodule

// File: rtl/tout_ctrl_chk.sv
module tout_ctrl_chk
  import tout_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCH-1:0]    irq_i,
  input logic              msel3_i,
  input logic [NCH-1:0]    tout_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NCH-1:0]    en_w,
  input logic [NCH-1:0]    act_w
);
  logic [NCH-1:0] ldr;
  assign ldr = {msel3_i ? irq_i[2] : irq_i[0], irq_i[0], irq_i[0], 1'b0};

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NCH] == '0);

  for (genvar k = 0; k < NCH; k++) begin : g_a
    a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_w[k] && !act_w[k] && irq_i[k] |=> tout_o[k] != $past(tout_o[k]));
    a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_w[k] && act_w[k] && ldr[k] && !irq_i[k] |=> tout_o[k]);
    a_r6_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_w[k] && act_w[k] && irq_i[k] |=> !tout_o[k]);
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_w[k] |=> tout_o[k] == $past(tout_o[k]) && act_w[k] == $past(act_w[k]));
    a_r9_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_i[k] && !(act_w[k] && ldr[k]) |=> act_w[k] == $past(act_w[k]));
  end
endmodule

bind tout_ctrl tout_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .msel3_i(msel3_i),
  .tout_o(tout_o), .rdata_o(rdata_o), .en_w(en_w), .act_w(act_w)
);

// File: tb/tout_ctrl_bench.sv
module tout_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0, byte_i = 1'b0, msel3_i = 1'b0;
  logic [0:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [3:0]  irq_i = '0;
  logic [3:0]  tout_o;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  tout_ctrl u_tout_ctrl (.*);

  // {irq, msel3, expected tout}; enable 1111, mode 1110 written beforehand
  localparam int NV = 11;
  localparam logic [8:0] VEC [NV] = '{
    {4'b0001, 1'b0, 4'b0001},  // R4 ch0 toggles; R9 followers still toggle mode
    {4'b1110, 1'b0, 4'b1111},  // R9 old mode used at the switching event
    {4'b0010, 1'b0, 4'b1101},  // R5 own reset
    {4'b0001, 1'b0, 4'b1110},  // R5 R7 leader 0 sets 1,2,3
    {4'b1000, 1'b0, 4'b0110},
    {4'b0100, 1'b1, 4'b1010},  // R7 ch3 led by ch2
    {4'b1100, 1'b1, 4'b0010},  // R6 ch3 collision
    {4'b0001, 1'b1, 4'b0111},  // R7 ch3 ignores ch0 when msel3=1
    {4'b0011, 1'b0, 4'b1100},  // R6 ch1 collision
    {4'b0000, 1'b0, 4'b1100},
    {4'b0101, 1'b0, 4'b1011}   // R6 ch2 collision
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic b, logic [15:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; byte_i = b; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; byte_i = 1'b0;
  endtask

  task automatic rd(logic a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse(logic [3:0] v, logic m, string req, logic [3:0] exp);
    @(negedge clk_i);
    irq_i = v; msel3_i = m;
    @(posedge clk_i);
    #1 chk(req, {12'h0, tout_o}, {12'h0, exp});
    @(negedge clk_i);
    irq_i = '0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 tout", {12'h0, tout_o}, 16'h0);
    rd(1'b0, d); chk("R1 enable", d, 16'h0);
    rd(1'b1, d); chk("R1 mode", d, 16'h0);

    wr(1'b1, 1'b0, 16'hFFFF);
    rd(1'b1, d); chk("R2 mode reserved", d, 16'h000E);
    wr(1'b0, 1'b0, 16'hFFF5);
    rd(1'b0, d); chk("R2 enable", d, 16'h0005);
    wr(1'b1, 1'b1, 16'hFF04);
    rd(1'b1, d); chk("R3 byte write", d, 16'h0004);
    rd(1'b0, d); chk("R3 other reg", d, 16'h0005);

    wr(1'b0, 1'b0, 16'h000F);
    wr(1'b1, 1'b0, 16'h000E);
    chk("R8 idle tout", {12'h0, tout_o}, 16'h0);

    for (int i = 0; i < NV; i++)
      pulse(VEC[i][8:5], VEC[i][4], $sformatf("R4-7 vec%0d", i), VEC[i][3:0]);

    // R8: disabled outputs ignore pulses
    wr(1'b0, 1'b0, 16'h0000);
    pulse(4'b1111, 1'b0, "R8 hold", 4'b1011);
    pulse(4'b0001, 1'b0, "R8 hold leader", 4'b1011);
    wr(1'b0, 1'b0, 16'h000F);

    // R9: ch1 back to toggle mode, applied at its next event
    wr(1'b1, 1'b0, 16'h000C);
    pulse(4'b0000, 1'b0, "R9 no event", 4'b1011);
    pulse(4'b0010, 1'b0, "R9 switch event", 4'b1001);
    pulse(4'b0001, 1'b0, "R9 leader ignored", 4'b1100);
    pulse(4'b0010, 1'b0, "R9 now toggles", 4'b1110);

    // R1: asynchronous reset clears outputs
    @(negedge clk_i); rst_ni = 1'b0;
    #1 chk("R1 async reset", {12'h0, tout_o}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    rd(1'b1, d); chk("R1 mode after reset", d, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule